// File: doc/BRIEF.md
# Indexed Colour Palette Port

This block holds a 256-entry colour lookup table and gives a host three small registers to reach it: a load-read-index register, a load-write-index register and one data register. Each table entry is a red, green and blue triple. The host moves one component per data access, in the order red, green, blue. After the blue access the active index steps forward by one, so a run of consecutive entries can be streamed without reloading the index. The read and write directions each keep their own index and component counter.

A control register holds a cursor-palette select bit. While this bit is set, the data register reaches a separate two-colour cursor palette, and the index does not step after blue. The same bit picks what a shared address holds: the pixel mask while the bit is clear, the DAC command byte while it is set. On the display side, a pixel index goes in and the table entry at (pixel index AND pixel mask) comes out one cycle later. The two cursor colours and the command byte are exported as plain outputs.

Host register addresses (`host_addr`): 0 is the mask or command register, 1 loads the read index, 2 loads the write index, 3 is the data register and 4 is the control register (bit 0 is cursor-palette select). Reading address 1 or 2 returns the current read or write index. Reading address 4 returns the select bit in bit 0. Other addresses read as 0 and ignore writes. A host read returns data on `host_rdata` with `host_rvalid` high in the cycle after the request.

Top module: `palette_port`

## Requirements
- R1: After reset the pixel mask reads 0xFF, the command byte reads 0x00, the control register reads 0, both index registers read 0 and `host_rvalid` is low.
- R2: After the write index is loaded, three data writes store red, green and blue of that entry in that order.
- R3: After the read index is loaded, three data reads return red, green and blue of that entry in that order, including when the reads are back to back.
- R4: In main-table mode the active index of a direction increments after its blue access and wraps from 255 to 0. Streaming continues into the next entry.
- R5: With cursor-palette select set, data writes and reads use cursor colour (index bit 0), shown on `cur_color0`/`cur_color1` as {red, green, blue}. The main table is left unchanged.
- R6: With cursor-palette select set, the index does not change after the blue access. The component counter still returns to red.
- R7: Address 0 accesses the pixel mask when cursor-palette select is 0 and the command byte (`dac_cmd`) when it is 1. A write to one leaves the other unchanged.
- R8: Loading either index register resets that direction's component counter to red.
- R9: `pix_rgb` equals {red, green, blue} of the entry at (`pix_idx` AND pixel mask), one cycle after `pix_idx` is presented.
- R10: A data write of one component updates only that component. An entry whose write sequence is abandoned keeps its remaining components.
- R11: Every host read request is answered with `host_rvalid` high in the next cycle. No other cycle has `host_rvalid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Host register address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, registered |
| host_rvalid | output | 1 | Read data valid |
| pix_idx | input | DW | Pixel index for lookup |
| pix_rgb | output | 3*DW | Looked-up colour {red, green, blue} |
| cur_color0 | output | 3*DW | Cursor colour 0 {red, green, blue} |
| cur_color1 | output | 3*DW | Cursor colour 1 {red, green, blue} |
| dac_cmd | output | DW | DAC command byte |

## Verification
A host read is due one cycle after its request, and pixel colours are due one cycle after `pix_idx` changes. Cursor colours, the command byte and index readbacks reflect a write from the cycle after it. The bench drives every input on the falling edge. A driver task queues the value each read should return, and a monitor compares it on the next falling edge at which `host_rvalid` is high. Pixel and cursor outputs are sampled on the falling edge one full cycle after the stimulus.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [2:0] {
    REG_MASK_CMD = 3'd0,
    REG_RD_IDX   = 3'd1,
    REG_WR_IDX   = 3'd2,
    REG_DATA     = 3'd3,
    REG_CTRL     = 3'd4
  } reg_addr_t;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_t;

  localparam int NUM_COMP = 3;

endpackage

// File: rtl/pal_comp_ram.sv
// One colour component plane: a single write port, a host read port with
// enable (acts as the read holding register), and a pixel lookup port.
module pal_comp_ram #(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          a_en,
  input  logic [IW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [IW-1:0] b_addr,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 2 ** IW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (a_en) a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end

endmodule

// File: rtl/pal_seq.sv
// Index and component sequencer for one access direction.
module pal_seq
  import pal_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] load_val,
  input  logic          step,
  input  logic          no_inc,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] idx_nxt,
  output comp_t         comp,
  output logic          moved
);
  comp_t comp_nxt;

  always_comb begin
    idx_nxt  = idx;
    comp_nxt = comp;
    moved    = 1'b0;
    if (load) begin
      idx_nxt  = load_val;
      comp_nxt = COMP_RED;
      moved    = 1'b1;
    end else if (step) begin
      if (comp == COMP_BLUE) begin
        comp_nxt = COMP_RED;
        if (!no_inc) begin
          idx_nxt = idx + 1'b1;
          moved   = 1'b1;
        end
      end else begin
        comp_nxt = comp_t'(comp + 2'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      comp <= COMP_RED;
    end else begin
      idx  <= idx_nxt;
      comp <= comp_nxt;
    end
  end

endmodule

// File: rtl/palette_port.sv
module palette_port
  import pal_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_sel,
  input  logic            host_we,
  input  logic [2:0]      host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_rvalid,
  input  logic [DW-1:0]   pix_idx,
  output logic [3*DW-1:0] pix_rgb,
  output logic [3*DW-1:0] cur_color0,
  output logic [3*DW-1:0] cur_color1,
  output logic [DW-1:0]   dac_cmd
);
  localparam int IW       = DW;
  localparam int CUR_ENTS = 2;

  // host decode
  logic wr_req, rd_req;
  logic wr_mask, wr_cmd, wr_ctrl, wr_ridx, wr_widx, wr_data, rd_data;
  assign wr_req  = host_sel && host_we;
  assign rd_req  = host_sel && !host_we;

  logic cursor_sel;
  logic [DW-1:0] pix_mask;
  logic [DW-1:0] cmd_q;

  assign wr_mask = wr_req && (host_addr == REG_MASK_CMD) && !cursor_sel;
  assign wr_cmd  = wr_req && (host_addr == REG_MASK_CMD) &&  cursor_sel;
  assign wr_ctrl = wr_req && (host_addr == REG_CTRL);
  assign wr_ridx = wr_req && (host_addr == REG_RD_IDX);
  assign wr_widx = wr_req && (host_addr == REG_WR_IDX);
  assign wr_data = wr_req && (host_addr == REG_DATA);
  assign rd_data = rd_req && (host_addr == REG_DATA);

  // control, mask, command
  always_ff @(posedge clk) begin
    if (rst) begin
      cursor_sel <= 1'b0;
      pix_mask   <= '1;
      cmd_q      <= '0;
    end else begin
      if (wr_ctrl) cursor_sel <= host_wdata[0];
      if (wr_mask) pix_mask   <= host_wdata;
      if (wr_cmd)  cmd_q      <= host_wdata;
    end
  end
  assign dac_cmd = cmd_q;

  // sequencers
  logic [IW-1:0] wr_idx, wr_idx_nxt, rd_idx, rd_idx_nxt;
  comp_t         wr_comp, rd_comp;
  logic          wr_moved, rd_moved;

  pal_seq #(.IW(IW)) u_wseq (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_widx),
    .load_val (host_wdata[IW-1:0]),
    .step     (wr_data),
    .no_inc   (cursor_sel),
    .idx      (wr_idx),
    .idx_nxt  (wr_idx_nxt),
    .comp     (wr_comp),
    .moved    (wr_moved)
  );

  pal_seq #(.IW(IW)) u_rseq (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_ridx),
    .load_val (host_wdata[IW-1:0]),
    .step     (rd_data),
    .no_inc   (cursor_sel),
    .idx      (rd_idx),
    .idx_nxt  (rd_idx_nxt),
    .comp     (rd_comp),
    .moved    (rd_moved)
  );

  // main table: one plane per component
  logic [DW-1:0] hold_q [NUM_COMP];
  logic [DW-1:0] look_q [NUM_COMP];
  logic [IW-1:0] look_addr;
  logic          hold_en;
  logic [IW-1:0] hold_addr;

  assign look_addr = pix_idx & pix_mask;
  assign hold_en   = rd_moved || rst;
  assign hold_addr = rst ? '0 : rd_idx_nxt;

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_plane
    logic plane_we;
    assign plane_we = wr_data && !cursor_sel && (wr_comp == comp_t'(c));

    pal_comp_ram #(.DW(DW), .IW(IW)) u_ram (
      .clk    (clk),
      .we     (plane_we),
      .waddr  (wr_idx),
      .wdata  (host_wdata),
      .a_en   (hold_en),
      .a_addr (hold_addr),
      .a_q    (hold_q[c]),
      .b_addr (look_addr),
      .b_q    (look_q[c])
    );
  end

  assign pix_rgb = {look_q[COMP_RED], look_q[COMP_GREEN], look_q[COMP_BLUE]};

  // cursor palette in flops
  logic [DW-1:0] cur_pal [CUR_ENTS][NUM_COMP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < CUR_ENTS; e++)
        for (int c = 0; c < NUM_COMP; c++)
          cur_pal[e][c] <= '0;
    end else if (wr_data && cursor_sel) begin
      cur_pal[wr_idx[0]][wr_comp] <= host_wdata;
    end
  end

  assign cur_color0 = {cur_pal[0][COMP_RED], cur_pal[0][COMP_GREEN], cur_pal[0][COMP_BLUE]};
  assign cur_color1 = {cur_pal[1][COMP_RED], cur_pal[1][COMP_GREEN], cur_pal[1][COMP_BLUE]};

  // host read mux, registered
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (host_addr)
      REG_MASK_CMD: rd_mux = cursor_sel ? cmd_q : pix_mask;
      REG_RD_IDX:   rd_mux = rd_idx;
      REG_WR_IDX:   rd_mux = wr_idx;
      REG_DATA:     rd_mux = cursor_sel ? cur_pal[rd_idx[0]][rd_comp] : hold_q[rd_comp];
      REG_CTRL:     rd_mux = {{(DW-1){1'b0}}, cursor_sel};
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_req;
      if (rd_req) host_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/pal_chk.sv
module pal_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_sel,
  input logic          host_we,
  input logic [2:0]    host_addr,
  input logic [DW-1:0] host_wdata,
  input logic          host_rvalid,
  input logic          cursor_sel,
  input logic [DW-1:0] wr_idx,
  input logic [DW-1:0] rd_idx,
  input logic [1:0]    wr_comp,
  input logic [1:0]    rd_comp,
  input logic [DW-1:0] pix_mask,
  input logic [DW-1:0] dac_cmd
);
  logic host_wr, host_rd;
  assign host_wr = host_sel && host_we;
  assign host_rd = host_sel && !host_we;

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid); // R11
  AST_RVALID_ONLY: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !host_rvalid); // R11
  AST_WIDX_LOAD: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd2) |=> (wr_idx == $past(host_wdata) && wr_comp == 2'd0)); // R8
  AST_RIDX_LOAD: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd1) |=> (rd_idx == $past(host_wdata) && rd_comp == 2'd0)); // R8
  AST_MAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd3 && !cursor_sel && wr_comp == 2'd2)
      |=> wr_idx == $past(wr_idx) + 1'b1); // R4
  AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd3 && cursor_sel && wr_comp == 2'd2)
      |=> ($stable(wr_idx) && wr_comp == 2'd0)); // R6
  AST_MASK_GUARD: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd0 && cursor_sel) |=> $stable(pix_mask)); // R7
  AST_CMD_GUARD: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd0 && !cursor_sel) |=> $stable(dac_cmd)); // R7

endmodule

bind palette_port pal_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_sel    (host_sel),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_rvalid (host_rvalid),
  .cursor_sel  (cursor_sel),
  .wr_idx      (wr_idx),
  .rd_idx      (rd_idx),
  .wr_comp     (wr_comp),
  .rd_comp     (rd_comp),
  .pix_mask    (pix_mask),
  .dac_cmd     (dac_cmd)
);

// File: tb/tb_palette_port.sv
module tb_palette_port;
  localparam int DW        = 8;
  localparam int CLK_PER   = 10;
  localparam int WDOG_CYC  = 20000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            host_sel = 1'b0;
  logic            host_we = 1'b0;
  logic [2:0]      host_addr = '0;
  logic [DW-1:0]   host_wdata = '0;
  logic [DW-1:0]   host_rdata;
  logic            host_rvalid;
  logic [DW-1:0]   pix_idx = '0;
  logic [3*DW-1:0] pix_rgb;
  logic [3*DW-1:0] cur_color0;
  logic [3*DW-1:0] cur_color1;
  logic [DW-1:0]   dac_cmd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #(CLK_PER/2) clk = ~clk;

  palette_port #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
    .cur_color0(cur_color0), .cur_color1(cur_color1), .dac_cmd(dac_cmd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
  endtask

  task automatic host_rd(input logic [2:0] a, input logic [DW-1:0] e, input string tag);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic pix_chk(input logic [DW-1:0] p, input logic [3*DW-1:0] e, input string tag);
    @(negedge clk);
    pix_idx = p;
    @(negedge clk);
    check(tag, pix_rgb, e);
  endtask

  // monitor: compares every returned read against the scoreboard
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rvalid after reset", host_rvalid, 0);
    rst = 1'b0;

    // R1 reset values
    host_rd(3'd0, 8'hFF, "R1 mask reset");
    host_rd(3'd1, 8'h00, "R1 read index reset");
    host_rd(3'd2, 8'h00, "R1 write index reset");
    host_rd(3'd4, 8'h00, "R1 control reset");
    idle();
    check("R1 command reset", dac_cmd, 0);

    // R2 R4 streaming two entries
    host_wr(3'd2, 8'd5);
    host_wr(3'd3, 8'h11); host_wr(3'd3, 8'h22); host_wr(3'd3, 8'h33);
    host_wr(3'd3, 8'h44); host_wr(3'd3, 8'h55); host_wr(3'd3, 8'h66);
    host_rd(3'd2, 8'd7, "R4 write index after two entries");
    // R3 back-to-back reads across entries
    host_wr(3'd1, 8'd5);
    host_rd(3'd3, 8'h11, "R3 red");   host_rd(3'd3, 8'h22, "R3 green");
    host_rd(3'd3, 8'h33, "R3 blue");  host_rd(3'd3, 8'h44, "R4 next red");
    host_rd(3'd3, 8'h55, "R4 next green"); host_rd(3'd3, 8'h66, "R4 next blue");
    idle();

    // R4 wrap 255 -> 0
    host_wr(3'd2, 8'd255);
    host_wr(3'd3, 8'hAA); host_wr(3'd3, 8'hBB); host_wr(3'd3, 8'hCC);
    host_wr(3'd3, 8'hDD); host_wr(3'd3, 8'hEE); host_wr(3'd3, 8'hFF);
    host_wr(3'd1, 8'd255);
    host_rd(3'd3, 8'hAA, "R4 wrap 255 red"); host_rd(3'd3, 8'hBB, "R4 wrap 255 green");
    host_rd(3'd3, 8'hCC, "R4 wrap 255 blue"); host_rd(3'd3, 8'hDD, "R4 wrap 0 red");
    host_rd(3'd3, 8'hEE, "R4 wrap 0 green"); host_rd(3'd3, 8'hFF, "R4 wrap 0 blue");
    host_rd(3'd1, 8'd1, "R4 read index after wrap");
    idle();

    // R8 index load resets component
    host_wr(3'd2, 8'd10);
    host_wr(3'd3, 8'h01); host_wr(3'd3, 8'h02); host_wr(3'd3, 8'h03);
    host_wr(3'd2, 8'd10); host_wr(3'd3, 8'h09);
    host_wr(3'd2, 8'd10); host_wr(3'd3, 8'h07);
    host_wr(3'd1, 8'd10);
    host_rd(3'd3, 8'h07, "R8 red after write reload");
    host_wr(3'd1, 8'd10);
    host_rd(3'd3, 8'h07, "R8 red after read reload");
    host_rd(3'd3, 8'h02, "R8 green kept");
    host_rd(3'd3, 8'h03, "R8 blue kept");
    idle();

    // R10 abandoned sequence keeps blue
    host_wr(3'd2, 8'd10);
    host_wr(3'd3, 8'h40); host_wr(3'd3, 8'h41);
    host_wr(3'd2, 8'd20);
    host_wr(3'd1, 8'd10);
    host_rd(3'd3, 8'h40, "R10 red"); host_rd(3'd3, 8'h41, "R10 green");
    host_rd(3'd3, 8'h03, "R10 blue unchanged");
    idle();

    // R9 pixel lookup with mask
    pix_chk(8'd5,  24'h112233, "R9 pixel 5");
    pix_chk(8'd0,  24'hDDEEFF, "R9 pixel 0");
    pix_chk(8'd10, 24'h404103, "R9 pixel 10");
    host_wr(3'd0, 8'h0F);
    host_rd(3'd0, 8'h0F, "R7 mask readback");
    idle();
    pix_chk(8'hF5, 24'h112233, "R9 masked F5");
    pix_chk(8'hFA, 24'h404103, "R9 masked FA");
    host_wr(3'd0, 8'hFF);
    idle();
    pix_chk(8'hFF, 24'hAABBCC, "R9 pixel 255");

    // R5 R6 R7 cursor palette mode
    host_wr(3'd4, 8'h01);
    host_rd(3'd4, 8'h01, "R5 control set");
    host_wr(3'd0, 8'h5A);
    host_rd(3'd0, 8'h5A, "R7 command readback");
    host_wr(3'd2, 8'd1);
    host_wr(3'd3, 8'hC1); host_wr(3'd3, 8'hC2); host_wr(3'd3, 8'hC3);
    host_wr(3'd3, 8'hC4);
    idle();
    check("R6 cursor1 no increment", cur_color1, 24'hC4C2C3);
    check("R7 command output", dac_cmd, 8'h5A);
    host_rd(3'd2, 8'd1, "R6 write index held");
    host_wr(3'd2, 8'd6);
    host_wr(3'd3, 8'h01); host_wr(3'd3, 8'h02); host_wr(3'd3, 8'h03);
    idle();
    check("R5 cursor0 colour", cur_color0, 24'h010203);
    host_wr(3'd1, 8'd1);
    host_rd(3'd3, 8'hC4, "R5 cursor read red");
    host_rd(3'd3, 8'hC2, "R5 cursor read green");
    host_rd(3'd3, 8'hC3, "R5 cursor read blue");
    host_rd(3'd3, 8'hC4, "R6 cursor read no increment");
    host_rd(3'd1, 8'd1, "R6 read index held");
    host_wr(3'd4, 8'h00);
    host_rd(3'd0, 8'hFF, "R7 mask untouched by command");
    idle();
    pix_chk(8'd6, 24'h445566, "R5 main entry 6 untouched");

    repeat (3) @(negedge clk);
    check("R11 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule